// File: doc/BRIEF.md
# Capacitive key matrix scan sequencer

This block runs the scan of a capacitive key matrix. It drives one row line high, waits for the lines to settle, and then steps an analog multiplexer across the sense columns. Each column gets two conversions through a start/done ADC handshake. The first samples a drain channel, which empties the converter's sampling capacitor; its result is thrown away. The second samples the column itself. Once every column of the row has been read, the row pin is pulled low together with all sense pins for a programmable discharge time, and the next row follows.

Each real sample is compared against a threshold for that key, held in a small register file that can be written at any time. The pressed/released result goes into an integrating debouncer. The debouncer changes a key's reported level only after the new level has been seen on a programmable number of consecutive scans. All delays are counted in clock cycles, using a cycles-per-microsecond parameter. Every pin output passes through one register stage.

Top module: `capkey_scan`

## Requirements
- R1: While a row is being read, exactly that row has `drv_oe` and `drv_lvl` set. All other drive pins and all sense pins have their enables low. At no time is more than one `drv_oe` bit set.
- R2: From the first cycle a row is driven high until the first `adc_start` of that row, exactly SETTLE_US*CYC_PER_US cycles pass.
- R3: For each column, in ascending order, the block issues a drain conversion with `adc_mux` = COLS, then a real conversion with `adc_mux` = the column index. Each `adc_start` is a one-cycle pulse, and the block waits for `adc_done` for as long as it takes.
- R4: The drain result never affects key state. A drain conversion that returns full scale does not press any key.
- R5: A column slot lasts at least READ_US*CYC_PER_US cycles, measured from its drain start to the next drain start, or to the start of discharge after the last column.
- R6: Discharge lasts clamp(`dis_us`, 3, 10)*CYC_PER_US cycles. During it, the active row has `drv_oe`=1 and `drv_lvl`=0, and all `sns_oe` bits are 1. `dis_us` is sampled when discharge begins.
- R7: Rows are scanned in order from 0 to ROWS-1. `scan_done` pulses for one cycle as the last row's discharge ends. If `en` is high at that point, the scan restarts at row 0; otherwise the block idles with no pin enables and no ADC starts.
- R8: The key at row r, column c has index r*COLS+c. A sample counts as pressed when `adc_data` >= threshold[index]. A threshold is written by holding `thr_we` high with `thr_addr` and `thr_wdata`.
- R9: A key's `key_state` bit flips only after N consecutive scans disagree with it. Any scan that agrees resets the run. N = `db_len`, where 0 selects 4 and values above 16 select 16.
- R10: `key_event` pulses for one cycle in the same cycle that a `key_state` bit changes.
- R11: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Keep scanning; checked when a scan ends and while idle |
| dis_us | input | 4 | Discharge time in µs, clamped to 3..10 |
| db_len | input | 5 | Debounce scan count; 0 selects 4, above 16 selects 16 |
| thr_we | input | 1 | Threshold write enable |
| thr_addr | input | KW | Threshold key index |
| thr_wdata | input | ADC_W | Threshold value |
| adc_start | output | 1 | One-cycle conversion start |
| adc_mux | output | MW | Multiplexer channel; COLS selects the drain channel |
| adc_done | input | 1 | Conversion complete strobe |
| adc_data | input | ADC_W | Conversion result, valid with adc_done |
| drv_oe | output | ROWS | Drive pin output enables |
| drv_lvl | output | ROWS | Drive pin levels (1 drive, 0 discharge) |
| sns_oe | output | COLS | Sense pin output enables (pull low) |
| key_state | output | ROWS*COLS | Debounced key levels, 1 = pressed |
| key_event | output | 1 | One-cycle strobe on any key change |
| scan_done | output | 1 | One-cycle strobe at end of scan |

## Verification
The bench sets a voltage for each key and applies it to whichever row and column the pins select. The drain channel always reads full scale, so any use of a drain result shows up as spurious presses.

Several patterns are exercised:
- keys exactly at their threshold and one count below it, which separates >= from >;
- a press held for fewer scans than the debounce length, which should never report;
- debounce settings of 0, 1 and an over-range value, which separate the default, the per-scan toggle and the clamp;
- discharge settings below, inside and above the legal range, each timed from the pins.

Row, column and drain ordering and the settle and slot lengths are measured on every row.

// File: rtl/capkey_pkg.sv
package capkey_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_DGO, S_DWAIT, S_RGO, S_RWAIT, S_HOLD, S_DISCH
  } seq_st_t;

  localparam int DIS_MIN_US = 3;
  localparam int DIS_MAX_US = 10;
  localparam int DB_DEFAULT = 4;
  localparam int DB_MAX     = 16;

  // discharge time in microseconds, limited to the legal window
  function automatic int dis_clamp(input logic [3:0] v);
    if (int'(v) < DIS_MIN_US) return DIS_MIN_US;
    if (int'(v) > DIS_MAX_US) return DIS_MAX_US;
    return int'(v);
  endfunction

  // effective debounce length: 0 picks the default, large values saturate
  function automatic logic [4:0] db_clamp(input logic [4:0] v);
    if (v == 5'd0) return 5'(DB_DEFAULT);
    if (int'(v) > DB_MAX) return 5'(DB_MAX);
    return v;
  endfunction

endpackage

// File: rtl/capkey_seq.sv
module capkey_seq
  import capkey_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int COLS       = 4,
  parameter int CYC_PER_US = 1,
  parameter int SETTLE_US  = 3,
  parameter int READ_US    = 1,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int KW   = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [3:0]    dis_us,
  input  logic          adc_done,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic [KW-1:0] key_idx,
  output logic          ph_drive,
  output logic          ph_dis,
  output logic          adc_go,
  output logic          drain,
  output logic          cap_en,
  output logic          scan_end
);

  localparam int MAXUS    = (SETTLE_US > READ_US) ?
                            ((SETTLE_US > DIS_MAX_US) ? SETTLE_US : DIS_MAX_US) :
                            ((READ_US > DIS_MAX_US) ? READ_US : DIS_MAX_US);
  localparam int TW       = $clog2(MAXUS * CYC_PER_US + 1);
  localparam int SET_C    = SETTLE_US * CYC_PER_US;
  localparam int READ_C   = READ_US * CYC_PER_US;

  seq_st_t       st;
  logic [TW-1:0] tmr;
  logic [TW-1:0] tmr_dec;
  logic          last_row, last_col;

  assign tmr_dec  = (tmr != '0) ? tmr - TW'(1) : '0;
  assign last_row = (row == RW'(ROWS - 1));
  assign last_col = (col == CW'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      row     <= '0;
      col     <= '0;
      key_idx <= '0;
      tmr     <= '0;
    end else begin
      case (st)
        S_IDLE: if (en) begin
          st      <= S_SETTLE;
          row     <= '0;
          col     <= '0;
          key_idx <= '0;
          tmr     <= TW'(SET_C - 1);
        end
        S_SETTLE: begin
          if (tmr == '0) begin
            st  <= S_DGO;
            tmr <= TW'(READ_C - 1);
          end else begin
            tmr <= tmr_dec;
          end
        end
        S_DGO: begin
          st  <= S_DWAIT;
          tmr <= tmr_dec;
        end
        S_DWAIT: begin
          tmr <= tmr_dec;
          if (adc_done) st <= S_RGO;
        end
        S_RGO: begin
          st  <= S_RWAIT;
          tmr <= tmr_dec;
        end
        S_RWAIT: begin
          tmr <= tmr_dec;
          if (adc_done) st <= S_HOLD;
        end
        S_HOLD: begin
          if (tmr == '0) begin
            key_idx <= key_idx + KW'(1);
            if (last_col) begin
              st  <= S_DISCH;
              col <= '0;
              tmr <= TW'(dis_clamp(dis_us) * CYC_PER_US - 1);
            end else begin
              st  <= S_DGO;
              col <= col + CW'(1);
              tmr <= TW'(READ_C - 1);
            end
          end else begin
            tmr <= tmr_dec;
          end
        end
        S_DISCH: begin
          if (tmr == '0) begin
            tmr <= TW'(SET_C - 1);
            if (last_row) begin
              row     <= '0;
              key_idx <= '0;
              st      <= en ? S_SETTLE : S_IDLE;
            end else begin
              row <= row + RW'(1);
              st  <= S_SETTLE;
            end
          end else begin
            tmr <= tmr_dec;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ph_drive = (st != S_IDLE) && (st != S_DISCH);
  assign ph_dis   = (st == S_DISCH);
  assign adc_go   = (st == S_DGO) || (st == S_RGO);
  assign drain    = (st == S_DGO) || (st == S_DWAIT);
  assign cap_en   = (st == S_RWAIT) && adc_done;
  assign scan_end = (st == S_DISCH) && (tmr == '0) && last_row;

  // R7: after the end of a scan, either row 0 is settling or the block idles
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    scan_end |=> ((st == S_SETTLE) && (row == '0)) || (st == S_IDLE));

  // R3: a real conversion is only ever launched right after its drain conversion
  p_real_after_drain_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_RGO) |-> ($past(st) == S_DWAIT));

  // R6: the discharge count never exceeds the longest legal window
  p_dis_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_DISCH) |-> (int'(tmr) < DIS_MAX_US * CYC_PER_US));

endmodule

// File: rtl/capkey_thr_ram.sv
module capkey_thr_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/capkey_debounce.sv
module capkey_debounce
  import capkey_pkg::*;
#(
  parameter int KEYS = 32,
  localparam int KW  = (KEYS > 1) ? $clog2(KEYS) : 1
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      db_len,
  input  logic            smp_vld,
  input  logic [KW-1:0]   smp_key,
  input  logic            smp_hit,
  output logic [KEYS-1:0] key_state,
  output logic            key_event
);

  logic [4:0] run_cnt [KEYS];
  logic [4:0] n_eff;
  logic [5:0] next_run;

  assign n_eff    = db_clamp(db_len);
  assign next_run = {1'b0, run_cnt[smp_key]} + 6'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_state <= '0;
      key_event <= 1'b0;
      for (int k = 0; k < KEYS; k++) run_cnt[k] <= '0;
    end else begin
      key_event <= 1'b0;
      if (smp_vld) begin
        if (smp_hit == key_state[smp_key]) begin
          run_cnt[smp_key] <= '0;
        end else if (next_run >= {1'b0, n_eff}) begin
          key_state[smp_key] <= smp_hit;
          run_cnt[smp_key]   <= '0;
          key_event          <= 1'b1;
        end else begin
          run_cnt[smp_key] <= next_run[4:0];
        end
      end
    end
  end

  // R10: a strobe always coincides with a changed level
  p_event_change_r10: assert property (@(posedge clk) disable iff (rst)
    key_event |-> (key_state != $past(key_state)));

  // R9: at most one key flips per cycle
  p_single_flip_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(key_state ^ $past(key_state)) <= 1);

endmodule

// File: rtl/capkey_scan.sv
module capkey_scan
  import capkey_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int COLS       = 4,
  parameter int ADC_W      = 12,
  parameter int CYC_PER_US = 1,
  parameter int SETTLE_US  = 3,
  parameter int READ_US    = 1,
  localparam int KEYS = ROWS * COLS,
  localparam int KW   = (KEYS > 1) ? $clog2(KEYS) : 1,
  localparam int MW   = $clog2(COLS + 1)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [3:0]       dis_us,
  input  logic [4:0]       db_len,
  input  logic             thr_we,
  input  logic [KW-1:0]    thr_addr,
  input  logic [ADC_W-1:0] thr_wdata,
  output logic             adc_start,
  output logic [MW-1:0]    adc_mux,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  output logic [ROWS-1:0]  drv_oe,
  output logic [ROWS-1:0]  drv_lvl,
  output logic [COLS-1:0]  sns_oe,
  output logic [KEYS-1:0]  key_state,
  output logic             key_event,
  output logic             scan_done
);

  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [RW-1:0]    row;
  logic [CW-1:0]    col;
  logic [KW-1:0]    key_idx;
  logic             ph_drive, ph_dis, adc_go, drain, cap_en, scan_end;
  logic [ADC_W-1:0] thr_rd;
  logic             smp_vld, smp_hit;
  logic [KW-1:0]    smp_key;

  capkey_seq #(
    .ROWS(ROWS), .COLS(COLS), .CYC_PER_US(CYC_PER_US),
    .SETTLE_US(SETTLE_US), .READ_US(READ_US)
  ) u_seq (
    .clk(clk), .rst(rst), .en(en), .dis_us(dis_us), .adc_done(adc_done),
    .row(row), .col(col), .key_idx(key_idx),
    .ph_drive(ph_drive), .ph_dis(ph_dis), .adc_go(adc_go),
    .drain(drain), .cap_en(cap_en), .scan_end(scan_end)
  );

  capkey_thr_ram #(.DEPTH(KEYS), .DW(ADC_W)) u_thr (
    .clk(clk), .we(thr_we), .waddr(thr_addr), .wdata(thr_wdata),
    .raddr(key_idx), .rdata(thr_rd)
  );

  // one register stage on every pin-facing output
  for (genvar r = 0; r < ROWS; r++) begin : g_row_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        drv_oe[r]  <= 1'b0;
        drv_lvl[r] <= 1'b0;
      end else begin
        drv_oe[r]  <= (row == RW'(r)) && (ph_drive || ph_dis);
        drv_lvl[r] <= (row == RW'(r)) && ph_drive;
      end
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_sense_pin
    always_ff @(posedge clk) begin
      if (rst) sns_oe[c] <= 1'b0;
      else     sns_oe[c] <= ph_dis;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_start <= 1'b0;
      adc_mux   <= '0;
      scan_done <= 1'b0;
      smp_vld   <= 1'b0;
      smp_hit   <= 1'b0;
      smp_key   <= '0;
    end else begin
      adc_start <= adc_go;
      adc_mux   <= drain ? MW'(COLS) : MW'(col);
      scan_done <= scan_end;
      smp_vld   <= cap_en;
      smp_hit   <= (adc_data >= thr_rd);
      smp_key   <= key_idx;
    end
  end

  capkey_debounce #(.KEYS(KEYS)) u_deb (
    .clk(clk), .rst(rst), .db_len(db_len),
    .smp_vld(smp_vld), .smp_key(smp_key), .smp_hit(smp_hit),
    .key_state(key_state), .key_event(key_event)
  );

  // R1: never two rows enabled at once
  p_one_row_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_oe));

  // R6: sense pins are only pulled while the row is held low
  p_sense_dis_r6: assert property (@(posedge clk) disable iff (rst)
    (|sns_oe) |-> ((drv_oe != '0) && ((drv_lvl & drv_oe) == '0)));

  // R3: conversion starts are single-cycle pulses
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

endmodule

// File: tb/sim_capkey_scan.sv
module sim_capkey_scan;

  localparam int ROWS = 8, COLS = 4, KEYS = 32, CYC = 2;
  localparam int SETC = 3 * CYC, SLOTC = 6 * CYC, DRAIN = COLS;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [3:0] dis_us = 4'd0;
  logic [4:0] db_len = 5'd0;
  logic thr_we = 1'b0;
  logic [4:0] thr_addr = '0;
  logic [11:0] thr_wdata = '0;
  logic adc_start, adc_done = 1'b0;
  logic [2:0] adc_mux;
  logic [11:0] adc_data = '0;
  logic [ROWS-1:0] drv_oe, drv_lvl;
  logic [COLS-1:0] sns_oe;
  logic [KEYS-1:0] key_state;
  logic key_event, scan_done;

  always #2 clk = ~clk;

  capkey_scan #(.ROWS(ROWS), .COLS(COLS), .ADC_W(12), .CYC_PER_US(CYC),
                .SETTLE_US(3), .READ_US(6)) u0 (
    .clk(clk), .rst(rst), .en(en), .dis_us(dis_us), .db_len(db_len),
    .thr_we(thr_we), .thr_addr(thr_addr), .thr_wdata(thr_wdata),
    .adc_start(adc_start), .adc_mux(adc_mux), .adc_done(adc_done),
    .adc_data(adc_data), .drv_oe(drv_oe), .drv_lvl(drv_lvl), .sns_oe(sns_oe),
    .key_state(key_state), .key_event(key_event), .scan_done(scan_done));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int aval [KEYS];
  int thr  [KEYS];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clamp_dis(input int v);
    return (v < 3) ? 3 : ((v > 10) ? 10 : v);
  endfunction
  function automatic int clamp_db(input int v);
    return (v == 0) ? 4 : ((v > 16) ? 16 : v);
  endfunction

  // ADC model: drain channel reads full scale, columns read the key voltage
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        int ch, rw;
        ch = int'(adc_mux);
        rw = -1;
        for (int r = 0; r < ROWS; r++) if (drv_oe[r] && drv_lvl[r]) rw = r;
        @(negedge clk);
        @(negedge clk);
        adc_done = 1'b1;
        adc_data = (ch == DRAIN || rw < 0) ? 12'hFFF : 12'(aval[rw * COLS + ch]);
        @(negedge clk);
        adc_done = 1'b0;
      end
    end
  end

  // pin timing monitor
  initial begin
    logic [ROWS-1:0] rd_prev = '0;
    bit dis_prev = 0, in_set = 0, have_slot = 0, sns_bad = 0;
    int set_cnt = 0, nst = 0, gap = 0, dcnt = 0, dexp = 0;
    forever begin
      logic [ROWS-1:0] rd;
      bit dis;
      @(negedge clk);
      if (rst) continue;
      rd  = drv_oe & drv_lvl;
      dis = (drv_oe != '0) && ((drv_oe & drv_lvl) == '0);
      gap++;
      if (rd != '0 && rd_prev == '0) begin
        in_set = 1; set_cnt = 0; nst = 0; have_slot = 0;
      end
      if (in_set) begin
        if (adc_start) begin
          chk(set_cnt == SETC, "R2 settle cycles", set_cnt, SETC);
          in_set = 0;
        end else set_cnt++;
      end
      if (adc_start) begin
        int e;
        e = (nst % 2 == 0) ? DRAIN : nst / 2;
        chk(int'(adc_mux) == e, "R3 mux order", adc_mux, e);
        chk($onehot(drv_oe) && drv_lvl == drv_oe && sns_oe == '0,
            "R1 pins while reading", {drv_oe, drv_lvl, sns_oe}, 0);
        nst++;
        if (adc_mux == 3'(DRAIN)) begin
          if (have_slot) chk(gap == SLOTC, "R5 slot length", gap, SLOTC);
          gap = 0; have_slot = 1;
        end
      end
      if (dis && !dis_prev) begin
        if (have_slot) chk(gap == SLOTC, "R5 last slot length", gap, SLOTC);
        have_slot = 0;
        dcnt = 0; sns_bad = 0;
        dexp = clamp_dis(int'(dis_us)) * CYC;
      end
      if (dis) begin
        dcnt++;
        if (sns_oe != '1) sns_bad = 1;
      end
      if (!dis && dis_prev) begin
        chk(dcnt == dexp, "R6 discharge cycles", dcnt, dexp);
        chk(!sns_bad, "R6 sense pins pulled", sns_bad, 0);
      end
      rd_prev = rd; dis_prev = dis;
    end
  end

  // scoreboard
  logic [KEYS-1:0] exp_q [$];
  int ev_q [$];
  logic [KEYS-1:0] m_st = '0;
  int m_cnt [KEYS];

  initial begin
    int ev_seen = 0;
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (key_event) ev_seen++;
      if (scan_done) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected scan_done", 1, 0);
        else begin
          logic [KEYS-1:0] ev;
          int ec;
          ev = exp_q.pop_front();
          ec = ev_q.pop_front();
          chk(key_state == ev, "R4 R8 R9 key_state", key_state, ev);
          chk(ev_seen == ec, "R10 key_event count", ev_seen, ec);
        end
        ev_seen = 0;
      end
    end
  end

  // push expectation for one scan, then wait for its end
  task automatic frame(input int dis, input int db, input bit keep_en);
    int n, evc;
    dis_us = 4'(dis);
    db_len = 5'(db);
    en = keep_en;
    n = clamp_db(db);
    evc = 0;
    for (int k = 0; k < KEYS; k++) begin
      bit hit;
      hit = aval[k] >= thr[k];
      if (hit == m_st[k]) m_cnt[k] = 0;
      else if (m_cnt[k] + 1 >= n) begin
        m_st[k] = hit; m_cnt[k] = 0; evc++;
      end else m_cnt[k]++;
    end
    exp_q.push_back(m_st);
    ev_q.push_back(evc);
    do @(negedge clk); while (!scan_done);
  endtask

  initial begin
    int dseq [6] = '{0, 3, 10, 15, 7, 5};
    for (int k = 0; k < KEYS; k++) begin
      thr[k] = 1000 + 50 * k; aval[k] = 100; m_cnt[k] = 0;
    end
    repeat (4) @(negedge clk);
    // R11: everything idle in reset
    chk(adc_start == 0 && drv_oe == 0 && drv_lvl == 0 && sns_oe == 0 &&
        key_state == 0 && key_event == 0 && scan_done == 0,
        "R11 reset outputs", {drv_oe, sns_oe, key_state}, 0);
    rst = 1'b0;
    for (int k = 0; k < KEYS; k++) begin
      thr_we = 1'b1; thr_addr = 5'(k); thr_wdata = 12'(thr[k]);
      @(negedge clk);
    end
    thr_we = 1'b0;
    en = 1'b1;
    // idle keys, default debounce
    for (int f = 0; f < 2; f++) frame(dseq[f % 6], 0, 1);
    // R8 boundary: equal presses, one below does not; R4 drain full scale ignored
    aval[5] = thr[5]; aval[6] = thr[6] - 1; aval[31] = 4095; aval[10] = thr[10] + 5;
    for (int f = 0; f < 6; f++) begin
      if (f == 3) aval[10] = 100;           // R9 short glitch of 3 scans
      frame(dseq[f % 6], 0, 1);
    end
    // R9 clamp: 20 behaves as 16
    aval[5] = 100;
    for (int f = 0; f < 17; f++) frame(dseq[(f + 2) % 6], 20, 1);
    // R9 length 1: every scan flips
    for (int f = 0; f < 4; f++) begin
      aval[0] = (f % 2 == 0) ? 4000 : 0;
      frame(dseq[(f + 1) % 6], 1, 1);
    end
    // R7: enable drops during a scan; scan completes, then idle
    frame(4, 1, 0);
    begin
      int starts = 0, oes = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (adc_start) starts++;
        if (drv_oe != 0 || sns_oe != 0) oes++;
      end
      chk(starts == 0, "R7 idle no conversions", starts, 0);
      chk(oes == 0, "R7 idle pins released", oes, 0);
    end
    chk(exp_q.size() == 0, "R7 all scans ended", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule